// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This engine keeps re-reading a serial flash device's status word on software's behalf. Each read is requested from a command sequencer that sits outside the block. The engine takes the returned bytes and compares the selected bits with an expected value. When they match, it raises a sticky match flag, which can also drive an interrupt. Software therefore configures the poll once and waits for the flag, instead of reading the device in a loop.

A poll starts with a `start` pulse while `enable` is high. The engine then loops: it requests a read, waits for the response, evaluates it, and idles for a programmable number of cycles before the next read. With auto-stop set, the loop ends at the first match. Otherwise it runs until an abort request or until `enable` drops. Every end of a poll is marked by a one-cycle `done` pulse. The last status word received stays visible on `last_status`.

Top module: `stpoll_engine`

## Requirements
- R1: After synchronous reset `rd_req`, `busy`, `done`, `match_flag` and `irq` are 0 and `last_status` is 0.
- R2: While idle, a `start` pulse with `enable` high raises `rd_req` and `busy` in the next cycle. `start` while `enable` is low has no effect. `rd_req` is only ever high while `busy` is high.
- R3: `rd_len` carries the configured status length code (0 = 1 byte, 1 = 2 bytes, 2 = 3 bytes, 3 = 4 bytes; byte 0 is bits 7:0). Bytes above that length are forced to 0 in `last_status` and are excluded from the comparison. `last_status` takes the response in the cycle after the `rsp_valid` cycle.
- R4: In all-bits mode (`cfg_any_mode` = 0), a response matches when every bit that is set in `cfg_mask` and inside the length equals the same bit of `cfg_match`. An empty effective mask always matches.
- R5: In any-bit mode (`cfg_any_mode` = 1), a response matches when at least one bit that is set in `cfg_mask` and inside the length equals the same bit of `cfg_match`. An empty effective mask never matches.
- R6: After a response that does not end the poll, `rd_req` stays low for exactly `cfg_interval` cycles before the next read. With an interval of 0, `rd_req` stays high without a gap.
- R7: With `cfg_auto_stop` = 1, the first matching response ends the poll. `busy` falls and `done` pulses high for one cycle in the next cycle.
- R8: With `cfg_auto_stop` = 0, polling continues after matches.
- R9: An abort request, or `enable` low, during a read lets that read finish and then ends the poll with a `done` pulse. During the idle gap it ends the poll in the next cycle with a `done` pulse, and no further read is issued.
- R10: `match_flag` is set in the cycle after a matching response and stays set until a `flag_clr` pulse. A set and a clear in the same cycle leave the flag set.
- R11: `irq` is high exactly when `match_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low stops polling |
| start | input | 1 | Pulse that begins polling from idle |
| abort_req | input | 1 | Pulse that requests the end of polling |
| cfg_mask | input | 32 | Bits that take part in the comparison |
| cfg_match | input | 32 | Expected status bit values |
| cfg_any_mode | input | 1 | 0 = all bits must match, 1 = any bit suffices |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_nbytes | input | 2 | Status length code (bytes minus one) |
| cfg_auto_stop | input | 1 | End polling at the first match |
| irq_en | input | 1 | Gates the match flag onto `irq` |
| flag_clr | input | 1 | Pulse that clears `match_flag` |
| rd_req | output | 1 | Read request to the sequencer, held until the response |
| rd_len | output | 2 | Status length code for the sequencer |
| rsp_valid | input | 1 | Sequencer response strobe |
| rsp_data | input | 32 | Status bytes returned by the sequencer |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse when polling ends |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| last_status | output | 32 | Last received status word, length-clipped |

## Verification
`rd_req` and `busy` follow `start` after one register stage. `last_status` and `match_flag` follow the `rsp_valid` cycle after one stage. `done` appears one cycle after the ending response, or one cycle after an abort seen in the gap. `irq` follows the flag in the same cycle. The bench updates a behavioural model at every rising edge from the same inputs. It compares every output 1 ns after that edge, so each result is checked in exactly the cycle it is due. Directed checks then count completed reads, measure the idle gap, and read back the final status and flag values.

// File: rtl/stpoll_pkg.sv
package stpoll_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_READ = 2'd1,
        PS_GAP  = 2'd2
    } poll_state_e;

    typedef enum logic {
        MM_ALL = 1'b0,
        MM_ANY = 1'b1
    } match_mode_e;

    typedef struct packed {
        logic hit;
        logic stop;
    } eval_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/stpoll_cmp.sv
module stpoll_cmp
    import stpoll_pkg::*;
#(
    parameter int NB    = 4,
    parameter int LEN_W = 2,
    localparam int W    = NB * BYTE_W
) (
    input  logic [W-1:0]     data,
    input  logic [W-1:0]     mask,
    input  logic [W-1:0]     expect_val,
    input  logic [LEN_W-1:0] nbytes,
    input  match_mode_e      mode,
    output logic [W-1:0]     clipped,
    output logic             hit
);
    logic [W-1:0] keep;
    logic [W-1:0] eff_mask;
    logic [W-1:0] same;

    for (genvar g = 0; g < NB; g++) begin : g_keep
        assign keep[g*BYTE_W +: BYTE_W] = {BYTE_W{LEN_W'(g) <= nbytes}};
    end

    assign clipped  = data & keep;
    assign eff_mask = mask & keep;
    assign same     = ~(data ^ expect_val);

    always_comb begin
        if (mode == MM_ANY) hit = |(same & eff_mask);
        else                hit = &(same | ~eff_mask);
    end
endmodule

// File: rtl/stpoll_gap_timer.sv
module stpoll_gap_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IVL_W-1:0] load_val,
    input  logic             clr,
    output logic             expired
);
    logic [IVL_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - IVL_W'(1);
    end

    assign expired = (cnt == IVL_W'(1));
endmodule

// File: rtl/stpoll_flag.sv
module stpoll_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/stpoll_engine.sv
module stpoll_engine
    import stpoll_pkg::*;
#(
    parameter int NBYTES_MAX = 4,
    parameter int IVL_W      = 16,
    localparam int STAT_W    = NBYTES_MAX * BYTE_W,
    localparam int LEN_W     = $clog2(NBYTES_MAX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              abort_req,
    input  logic [STAT_W-1:0] cfg_mask,
    input  logic [STAT_W-1:0] cfg_match,
    input  logic              cfg_any_mode,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic [LEN_W-1:0]  cfg_nbytes,
    input  logic              cfg_auto_stop,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              rd_req,
    output logic [LEN_W-1:0]  rd_len,
    input  logic              rsp_valid,
    input  logic [STAT_W-1:0] rsp_data,
    output logic              busy,
    output logic              done,
    output logic              match_flag,
    output logic              irq,
    output logic [STAT_W-1:0] last_status
);
    poll_state_e       state;
    logic              stop_pend;
    logic [STAT_W-1:0] clipped;
    logic              quit;
    logic              rsp_take;
    logic              gap_done;
    eval_t             ev;

    stpoll_cmp #(.NB(NBYTES_MAX), .LEN_W(LEN_W)) u_cmp (
        .data       (rsp_data),
        .mask       (cfg_mask),
        .expect_val (cfg_match),
        .nbytes     (cfg_nbytes),
        .mode       (match_mode_e'(cfg_any_mode)),
        .clipped    (clipped),
        .hit        (ev.hit)
    );

    assign quit     = abort_req | ~enable;
    assign rsp_take = (state == PS_READ) && rsp_valid;
    assign ev.stop  = stop_pend | quit | (ev.hit & cfg_auto_stop);

    stpoll_gap_timer #(.IVL_W(IVL_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (rsp_take && !ev.stop),
        .load_val (cfg_interval),
        .clr      ((state == PS_GAP) && quit),
        .expired  (gap_done)
    );

    stpoll_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (rsp_take && ev.hit),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (match_flag),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PS_IDLE;
            stop_pend   <= 1'b0;
            done        <= 1'b0;
            last_status <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                PS_IDLE: begin
                    stop_pend <= 1'b0;
                    if (start && enable) state <= PS_READ;
                end
                PS_READ: begin
                    if (quit) stop_pend <= 1'b1;
                    if (rsp_valid) begin
                        last_status <= clipped;
                        if (ev.stop) begin
                            state     <= PS_IDLE;
                            done      <= 1'b1;
                            stop_pend <= 1'b0;
                        end else if (cfg_interval != '0) begin
                            state <= PS_GAP;
                        end
                    end
                end
                PS_GAP: begin
                    if (quit) begin
                        state <= PS_IDLE;
                        done  <= 1'b1;
                    end else if (gap_done) begin
                        state <= PS_READ;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign rd_req = (state == PS_READ);
    assign busy   = (state != PS_IDLE);
    assign rd_len = cfg_nbytes;
endmodule

// File: rtl/stpoll_checker.sv
module stpoll_checker #(
    parameter int STAT_W = 32,
    parameter int IVL_W  = 16,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              start,
    input logic              abort_req,
    input logic [IVL_W-1:0]  cfg_interval,
    input logic              irq_en,
    input logic              flag_clr,
    input logic              rd_req,
    input logic [LEN_W-1:0]  rd_len,
    input logic              rsp_valid,
    input logic              busy,
    input logic              done,
    input logic              match_flag,
    input logic              irq,
    input logic [STAT_W-1:0] last_status
);
    function automatic logic [STAT_W-1:0] outside(input logic [LEN_W-1:0] len);
        logic [STAT_W-1:0] m;
        for (int b = 0; b < STAT_W / 8; b++)
            m[b*8 +: 8] = (b > int'(len)) ? 8'hFF : 8'h00;
        return m;
    endfunction

    p_req_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy);
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && enable) |=> rd_req);
    p_clip_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rsp_valid) |=> ((last_status & outside($past(rd_len))) == '0));
    p_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rsp_valid && cfg_interval != '0) |=> !rd_req);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_gap_quit_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_req && (abort_req || !enable)) |=> (!busy && done));
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_clr) |=> match_flag);
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && flag_clr && !(rd_req && rsp_valid)) |=> !match_flag);
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);
endmodule

bind stpoll_engine stpoll_checker #(.STAT_W(STAT_W), .IVL_W(IVL_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/stpoll_engine_bench.sv
module stpoll_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, start = 1'b0, abort_req = 1'b0;
    logic [31:0] cfg_mask = '0, cfg_match = '0;
    logic        cfg_any_mode = 1'b0;
    logic [15:0] cfg_interval = '0;
    logic [1:0]  cfg_nbytes = '0;
    logic        cfg_auto_stop = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic        rd_req;
    logic [1:0]  rd_len;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        busy, done, match_flag, irq;
    logic [31:0] last_status;

    always #5 clk = ~clk;

    stpoll_engine u_stpoll_engine (.*);

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // sequencer stand-in: answers each request after two low-phase samples
    logic [31:0] stat_q[$];
    int lat = 0, reads = 0;
    always @(negedge clk) begin
        if (rsp_valid) rsp_valid = 1'b0;
        else if (rd_req) begin
            lat++;
            if (lat >= 2) begin
                lat = 0;
                rsp_valid = 1'b1;
                rsp_data = (stat_q.size() != 0) ? stat_q.pop_front() : 32'h0;
                reads++;
            end
        end else lat = 0;
    end

    // behavioural reference
    int          m_st = 0, m_cnt = 0;
    bit          m_stop = 0, m_flag = 0, m_done = 0;
    logic [31:0] m_last = '0;
    always @(posedge clk) begin
        logic [31:0] keep;
        bit hit, quit;
        keep = (cfg_nbytes == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (int'(cfg_nbytes) + 1))) - 1);
        if (cfg_any_mode) hit = ((~(rsp_data ^ cfg_match)) & cfg_mask & keep) != 0;
        else              hit = ((rsp_data ^ cfg_match) & cfg_mask & keep) == 0;
        quit = abort_req || !enable;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_stop = 0; m_flag = 0; m_done = 0; m_last = '0;
        end else begin
            m_done = 0;
            if (m_st == 1 && rsp_valid && hit) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (m_st == 0) begin
                m_stop = 0;
                if (start && enable) m_st = 1;
            end else if (m_st == 1) begin
                if (quit) m_stop = 1;
                if (rsp_valid) begin
                    m_last = rsp_data & keep;
                    if (m_stop || (hit && cfg_auto_stop)) begin
                        m_st = 0; m_done = 1; m_stop = 0;
                    end else if (cfg_interval != 0) begin
                        m_st = 2; m_cnt = int'(cfg_interval);
                    end
                end
            end else begin
                if (quit) begin m_st = 0; m_done = 1; end
                else if (m_cnt == 1) m_st = 1;
                else m_cnt--;
            end
        end
    end

    int gap_run = 0, last_gap = -1, done_cnt = 0;
    always @(posedge clk) begin
        #1;
        chk(rd_req == (m_st == 1), "R2", 32'(rd_req), 32'(m_st == 1));
        chk(busy == (m_st != 0), "R7", 32'(busy), 32'(m_st != 0));
        chk(done == m_done, "R9", 32'(done), 32'(m_done));
        chk(match_flag == m_flag, "R10", 32'(match_flag), 32'(m_flag));
        chk(irq == (m_flag && irq_en), "R11", 32'(irq), 32'(m_flag && irq_en));
        chk(last_status == m_last, "R3", last_status, m_last);
        if (done) done_cnt++;
        if (!busy) gap_run = 0;
        else if (!rd_req) gap_run++;
        else if (gap_run > 0) begin last_gap = gap_run; gap_run = 0; end
    end

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int r0, d0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rd_req && !busy && !done, "R1", {29'b0, rd_req, busy, done}, 32'h0);
        chk(!match_flag && !irq && last_status == 0, "R1", last_status, 32'h0);
        rst = 1'b0;

        // R2: start ignored while disabled
        pulse_start();
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req, "R2", 32'(busy), 32'h0);

        // R4/R6/R7: all-bits wait for bit0 clear, 1 byte, gap 3, auto-stop
        enable = 1'b1; cfg_mask = 32'h01; cfg_match = 32'h00; cfg_interval = 16'd3;
        cfg_auto_stop = 1'b1; irq_en = 1'b1;
        stat_q = '{32'h01, 32'h03, 32'hFE};
        r0 = reads; d0 = done_cnt;
        pulse_start();
        chk(rd_req, "R2", 32'(rd_req), 32'h1);
        wait_idle(); @(negedge clk);
        chk(reads - r0 == 3, "R7", 32'(reads - r0), 32'd3);
        chk(last_gap == 3, "R6", 32'(last_gap), 32'd3);
        chk(last_status == 32'hFE, "R4", last_status, 32'hFE);
        chk(match_flag && irq, "R11", 32'(irq), 32'h1);
        chk(done_cnt - d0 == 1, "R7", 32'(done_cnt - d0), 32'd1);

        // R10: clear the flag
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(!match_flag && !irq, "R10", 32'(match_flag), 32'h0);

        // R5/R6: any-bit mode, gap 0, irq masked
        cfg_any_mode = 1'b1; cfg_mask = 32'h0F; cfg_match = 32'h0F; cfg_interval = 16'd0;
        irq_en = 1'b0; last_gap = -1;
        stat_q = '{32'h30, 32'h04};
        r0 = reads;
        pulse_start(); wait_idle(); @(negedge clk);
        chk(reads - r0 == 2, "R5", 32'(reads - r0), 32'd2);
        chk(last_gap == -1, "R6", 32'(last_gap), 32'hFFFF_FFFF);
        chk(match_flag && !irq, "R11", 32'(irq), 32'h0);

        // R5: empty mask never matches in any-bit mode
        cfg_mask = 32'h0; cfg_auto_stop = 1'b0; cfg_interval = 16'd1;
        stat_q = '{32'h0F, 32'h0F};
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        r0 = reads;
        pulse_start();
        while (reads - r0 < 2) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(!match_flag && busy, "R5", 32'(match_flag), 32'h0);
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        wait_idle();

        // R3/R4: two bytes, upper bytes ignored, empty-mask-free full mask
        cfg_any_mode = 1'b0; cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'h0000_1234;
        cfg_nbytes = 2'd1; cfg_auto_stop = 1'b1; cfg_interval = 16'd2;
        stat_q = '{32'hABCD_1234};
        pulse_start();
        chk(rd_len == 2'd1, "R3", 32'(rd_len), 32'd1);
        wait_idle(); @(negedge clk);
        chk(last_status == 32'h0000_1234, "R3", last_status, 32'h0000_1234);
        chk(match_flag, "R4", 32'(match_flag), 32'h1);

        // R8/R9: keep polling after matches, abort during a read
        cfg_nbytes = 2'd0; cfg_mask = 32'h80; cfg_match = 32'h80; cfg_auto_stop = 1'b0;
        stat_q = '{32'h80, 32'h80, 32'h80, 32'h80, 32'h80, 32'h80};
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        r0 = reads; d0 = done_cnt;
        pulse_start();
        while (reads - r0 < 4) @(negedge clk);
        while (!rd_req) @(negedge clk);
        chk(busy && match_flag, "R8", 32'(busy), 32'h1);
        r0 = reads;
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        wait_idle(); @(negedge clk);
        chk(reads - r0 <= 1 && !busy, "R9", 32'(reads - r0), 32'd1);
        chk(done_cnt - d0 == 1, "R9", 32'(done_cnt - d0), 32'd1);

        // R9: abort during the gap issues no further read
        cfg_interval = 16'd20;
        stat_q = '{32'h00};
        d0 = done_cnt;
        pulse_start();
        while (rd_req || !busy) @(negedge clk);
        r0 = reads;
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        chk(!busy && done, "R9", 32'(busy), 32'h0);
        repeat (5) @(negedge clk);
        chk(reads == r0 && done_cnt - d0 == 1, "R9", 32'(reads - r0), 32'h0);

        // R9: enable low during the gap also ends polling
        pulse_start();
        while (rd_req || !busy) @(negedge clk);
        enable = 1'b0; @(negedge clk);
        chk(!busy, "R9", 32'(busy), 32'h0);
        enable = 1'b1;

        // R4: empty mask always matches in all-bits mode
        cfg_mask = 32'h0; cfg_auto_stop = 1'b1; cfg_interval = 16'd0;
        stat_q = '{32'h55};
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        r0 = reads;
        pulse_start(); wait_idle(); @(negedge clk);
        chk(reads - r0 == 1 && match_flag, "R4", 32'(reads - r0), 32'd1);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule